// File: doc/BRIEF.md
# Gated Clock Divider

This block makes a slower clock for one peripheral from a faster input clock. Software programs a divide code and an enable bit through a small register port. The block then drives the divided clock and a one-cycle strobe, in the input clock domain, that marks the last input cycle of each output period. A parameter picks the code style. In the narrow style the code is a plain 5-bit ratio. In the wide style the code has 6 bits, and its top bit turns the low five bits into a coarse count of 64-cycle units.

A new code does not cut the running period short. It is held as pending until the current output period ends. A status word shows two identical busy bits for as long as a change is pending, so software can poll for completion. Clearing the enable bit also waits for the end of the period. The output then stays low and the internal counter is held at zero, so the next enable starts a complete first period.

Top module: `gated_clk_div`

## Requirements
- R1: In narrow mode a code N from 1 to 31 gives an output period of N input cycles, with the divided clock high for floor(N/2) of those cycles.
- R2: Code 0 selects the largest ratio: 32 in narrow mode and 64 in wide mode.
- R3: In wide mode a code with bit 5 set gives a ratio of 64 times bits 4:0. Code 0x20 gives 64.
- R4: In wide mode a code with bit 5 clear is used directly as the ratio (1 to 31).
- R5: With ratio 1 and the output enabled, the divided clock follows the input clock: high in the input high phase and low in the low phase.
- R6: Bit 0 of the register at address 2 is the enable and reads back as written. The other bits read zero.
- R7: Clearing the enable stops the output at the end of the current period. Afterwards the divided clock stays low and no strobe appears. After the enable is set again, the first strobe comes N+1 input cycles after the enabling write edge, so the first period is complete.
- R8: Address 0 is the status word. It reads 0x18 (bits 3 and 4 set) while a written code is pending and 0x00 otherwise. It reads 0x18 in the cycle right after a code write.
- R9: A written code takes effect only after the current output period ends. Busy clears no later than old-ratio plus one cycles after the write.
- R10: The strobe is high for exactly one input cycle per output period, in the last input cycle of that period.
- R11: Address 1 reads back the most recently written code. After reset, the code is 0 and the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address: 0 status, 1 code, 2 enable |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| divClk | output | 1 | Divided, gated output clock |
| divPulse | output | 1 | One-cycle strobe on the last input cycle of each output period |

## Verification
The checker covers the following on every cycle:
- a code write raises busy, and busy falls on the first period end that has no competing write;
- the status word holds exactly the busy pattern;
- the strobe never repeats in back-to-back cycles unless the ratio is 1;
- the gate closes only in the cycle right after a strobe;
- the enable reads back as written.

Only the directed scenarios can show the remaining behaviour:
- the actual period and high time for each code, including code 0 and the coarse wide-mode codes;
- that a change written mid-period leaves that period at its old length;
- the pass-through shape at ratio 1;
- the exact delay to the first strobe after re-enabling.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int COARSE_SHIFT = 6;   // coarse range unit is 64 input cycles
  localparam int BUSY_LO = 3;
  localparam int BUSY_HI = 4;
  localparam int EN_BIT = 0;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CODE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;      // counter runs and slow output may go high
    logic passOne;  // ratio is 1: input clock is passed through
  } gcdStrobe_t;
endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
#(
  parameter int WIDE_CODE = 0,
  parameter int CODE_W = 5,
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               atEnd,
  output logic [DATA_W-1:0]  regRdata,
  output logic [RATIO_W-1:0] ratio,
  output gcdStrobe_t         strobe,
  output logic               busy,
  output logic               gateOn
);
  localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(1 << CODE_W);
  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

  logic [CODE_W-1:0]  pendCode;
  logic [CODE_W-1:0]  activeCode;
  logic               enReg;
  logic [RATIO_W-1:0] scaled;
  logic               codeWr;
  logic               ctrlWr;
  logic               applyNow;
  logic               unusedWdata;

  assign codeWr   = regWe && (regAddr == ADDR_CODE);
  assign ctrlWr   = regWe && (regAddr == ADDR_CTRL);
  // a fresh write wins over an apply in the same cycle
  assign applyNow = busy && !codeWr && (!gateOn || atEnd);
  assign unusedWdata = ^regWdata;

  generate
    if (WIDE_CODE != 0) begin : g_wide
      always_comb begin
        if (activeCode[CODE_W-1])
          scaled = RATIO_W'(activeCode[CODE_W-2:0]) << COARSE_SHIFT;
        else
          scaled = RATIO_W'(activeCode);
      end
    end else begin : g_narrow
      always_comb scaled = RATIO_W'(activeCode);
    end
  endgenerate

  // a zero result stands for the largest ratio
  assign ratio = (scaled == '0) ? MAX_RATIO : scaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCode   <= '0;
      activeCode <= '0;
      busy       <= 1'b0;
      enReg      <= 1'b0;
      gateOn     <= 1'b0;
    end else begin
      if (codeWr) begin
        pendCode <= regWdata[CODE_W-1:0];
        busy     <= 1'b1;
      end else if (applyNow) begin
        activeCode <= pendCode;
        busy       <= 1'b0;
      end
      if (ctrlWr) enReg <= regWdata[EN_BIT];
      if (!gateOn && enReg)
        gateOn <= 1'b1;
      else if (gateOn && !enReg && atEnd)
        gateOn <= 1'b0;
    end
  end

  assign strobe.run     = gateOn;
  assign strobe.passOne = gateOn && (ratio == RATIO_ONE);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_STATUS: begin
        regRdata[BUSY_HI] = busy;
        regRdata[BUSY_LO] = busy;
      end
      ADDR_CODE: regRdata = DATA_W'(pendCode);
      ADDR_CTRL: regRdata[EN_BIT] = enReg;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  gcdStrobe_t         strobe,
  input  logic [RATIO_W-1:0] ratio,
  output logic               atEnd,
  output logic               divClk,
  output logic               divPulse
);
  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt;
  logic               slowQ;
  logic               passGate;

  assign atEnd = strobe.run && (cnt == (ratio - RATIO_ONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      slowQ <= 1'b0;
    end else begin
      if (!strobe.run || atEnd) cnt <= '0;
      else                      cnt <= cnt + RATIO_ONE;
      // high phase registered one cycle behind the count
      slowQ <= strobe.run && (cnt < (ratio >> 1));
    end
  end

  // gate for ratio one changes only while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) passGate <= 1'b0;
    else       passGate <= strobe.passOne;
  end

  assign divClk   = slowQ | (clk & passGate);
  assign divPulse = atEnd;
endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
  import gcd_pkg::*;
#(
  parameter int WIDE_CODE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              divClk,
  output logic              divPulse
);
  localparam int CODE_W  = (WIDE_CODE != 0) ? 6 : 5;
  localparam int RATIO_W = (WIDE_CODE != 0) ? 11 : 6;

  gcdStrobe_t         strobe;
  logic [RATIO_W-1:0] ratio;
  logic               atEnd;
  logic               busy;
  logic               gateOn;

  gcd_ctrl #(
    .WIDE_CODE(WIDE_CODE),
    .CODE_W   (CODE_W),
    .RATIO_W  (RATIO_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .atEnd   (atEnd),
    .regRdata(regRdata),
    .ratio   (ratio),
    .strobe  (strobe),
    .busy    (busy),
    .gateOn  (gateOn)
  );

  gcd_datapath #(
    .RATIO_W(RATIO_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ratio   (ratio),
    .atEnd   (atEnd),
    .divClk  (divClk),
    .divPulse(divPulse)
  );
endmodule

// File: rtl/gcd_checker.sv
module gcd_checker
  import gcd_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [DATA_W-1:0]  regRdata,
  input logic               divPulse,
  input logic               busy,
  input logic               gateOn,
  input logic [RATIO_W-1:0] ratio
);
  // R9: a code write leaves a pending change behind
  a_r9_write_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CODE) |=> busy);

  // R9: the pending change is applied at the first period end without a competing write
  a_r9_busy_clears_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (busy && divPulse && !(regWe && regAddr == ADDR_CODE)) |=> !busy);

  // R8: status word carries only the busy pattern
  a_r8_status_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS && busy) |-> (regRdata == 8'h18));

  a_r8_status_idle: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS && !busy) |-> (regRdata == 8'h00));

  // R10: one strobe per period, never two in a row above ratio one
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (divPulse && !busy && ratio != RATIO_W'(1)) |=> !divPulse);

  // R7: the gate only closes right after a period end
  a_r7_close_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> $past(divPulse));

  // R6: enable bit reads back as written
  a_r6_enable_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CTRL) |=>
      (regAddr != ADDR_CTRL || regRdata[EN_BIT] == $past(regWdata[EN_BIT])));
endmodule

bind gated_clk_div gcd_checker #(.RATIO_W(RATIO_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .divPulse(divPulse),
  .busy    (busy),
  .gateOn  (gateOn),
  .ratio   (ratio)
);

// File: tb/gated_clk_div_bench.sv
module gated_clk_div_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       weN = 1'b0;
  logic       weW = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdN, rdW;
  logic       dclkN, dclkW, pN, pW;
  int vecs = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_clk_div u_gated_clk_div (
    .clk(clk), .rstN(rstN), .regWe(weN), .regAddr(addr), .regWdata(wdata),
    .regRdata(rdN), .divClk(dclkN), .divPulse(pN)
  );

  gated_clk_div #(.WIDE_CODE(1)) u_wide (
    .clk(clk), .rstN(rstN), .regWe(weW), .regAddr(addr), .regWdata(wdata),
    .regRdata(rdW), .divClk(dclkW), .divPulse(pW)
  );

  function automatic logic pulseOf(bit w);
    return w ? pW : pN;
  endfunction
  function automatic logic clkOf(bit w);
    return w ? dclkW : dclkN;
  endfunction
  function automatic logic [7:0] rdOf(bit w);
    return w ? rdW : rdN;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkLe(string req, string what, int act, int lim);
    vecs++;
    if (act > lim) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected<=%0d", req, what, act, lim);
    end
  endtask

  task automatic wr(bit w, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; weN = !w; weW = w;
    @(negedge clk);
    weN = 1'b0; weW = 1'b0; addr = 2'd0;
  endtask

  task automatic rdReg(bit w, logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdOf(w));
    addr = 2'd0;
  endtask

  // leaves the bench at negedge+1 with a strobe present
  task automatic waitPulse(bit w, output int k);
    k = 0;
    while (!pulseOf(w) && k < 5000) begin
      @(negedge clk); #1; k++;
    end
  endtask

  // R1 R10: spacing of strobes and high cycles of the divided clock
  task automatic measure(bit w, int exp, string req);
    int k, p, hi;
    @(negedge clk); #1;
    waitPulse(w, k);
    p = 0; hi = 0;
    do begin
      @(negedge clk); #1;
      p++;
      if (clkOf(w)) hi++;
    end while (!pulseOf(w) && p < 5000);
    check(req, "period,R10", p, exp);
    if (exp > 1) check(req, "high cycles", hi, exp / 2);
  endtask

  // R8 R9: busy shows at once and clears within one old period
  task automatic setCode(bit w, logic [7:0] code, int oldRatio);
    int k;
    wr(w, 2'd1, code);
    k = 1; #1;
    check("R8", "busy after write", int'(rdOf(w)), 8'h18);
    while (rdOf(w) != 8'h00 && k < 5000) begin
      @(negedge clk); #1; k++;
    end
    checkLe("R9", "busy clear cycles", k, oldRatio + 1);
    check("R8", "idle status", int'(rdOf(w)), 0);
  endtask

  task automatic tReset();
    int v;
    #1;
    check("R8", "reset status N", int'(rdN), 0);
    check("R8", "reset status W", int'(rdW), 0);
    check("R7", "reset pulse", int'(pN | pW), 0);
    check("R7", "reset clock", int'(dclkN | dclkW), 0);
    rdReg(0, 2'd1, v); check("R11", "reset code", v, 0);
    rdReg(0, 2'd2, v); check("R6", "reset enable", v, 0);
  endtask

  task automatic tEnable();
    int k, v;
    setCode(0, 8'd5, 32);
    rdReg(0, 2'd1, v); check("R11", "code readback", v, 5);
    wr(0, 2'd2, 8'h01);
    k = 1; #1;
    while (!pN && k < 5000) begin
      @(negedge clk); #1; k++;
    end
    check("R7", "first strobe after enable", k, 6);
    rdReg(0, 2'd2, v); check("R6", "enable readback", v, 1);
    measure(0, 5, "R1");
  endtask

  task automatic tNarrowCodes();
    int codes[4] = '{3, 7, 31, 2};
    int prev = 5;
    foreach (codes[i]) begin
      setCode(0, 8'(codes[i]), prev);
      measure(0, codes[i], "R1");
      prev = codes[i];
    end
    setCode(0, 8'd0, prev);
    measure(0, 32, "R2");
  endtask

  task automatic tSwitch();
    int k;
    @(negedge clk); #1;
    waitPulse(0, k);
    repeat (10) @(negedge clk);
    wr(0, 2'd1, 8'd9);
    k = 1; #1;
    check("R8", "busy mid period", int'(rdN), 8'h18);
    while (!pN && k < 5000) begin
      @(negedge clk); #1; k++;
    end
    check("R9", "old period completes", k, 21);
    @(negedge clk); #1;
    check("R9", "busy cleared after period end", int'(rdN), 0);
    measure(0, 9, "R9");
  endtask

  task automatic tRatioOne();
    int hiOk = 0, loOk = 0, pOk = 0;
    setCode(0, 8'd1, 9);
    repeat (6) begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (dclkN) hiOk++;
      @(negedge clk); #1;
      if (!dclkN) loOk++;
      if (pN) pOk++;
    end
    check("R5", "high phase follows clk", hiOk, 6);
    check("R5", "low phase follows clk", loOk, 6);
    check("R10", "strobe every cycle at ratio 1", pOk, 6);
  endtask

  task automatic quiet(string what);
    int hi = 0, pul = 0;
    repeat (40) begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (dclkN) hi++;
      @(negedge clk); #1;
      if (dclkN) hi++;
      if (pN) pul++;
    end
    check("R7", {what, " clock high samples"}, hi, 0);
    check("R7", {what, " strobes"}, pul, 0);
  endtask

  task automatic tDisable();
    setCode(0, 8'd6, 1);
    measure(0, 6, "R1");
    wr(0, 2'd2, 8'h00);
    repeat (8) @(negedge clk);
    quiet("off at ratio 6");
    // ratio one while off, then on and off again
    setCode(0, 8'd1, 6);
    wr(0, 2'd2, 8'h01);
    repeat (3) @(negedge clk);
    @(posedge clk); #(CLK_PERIOD/4);
    check("R5", "pass-through after enable", int'(dclkN), 1);
    wr(0, 2'd2, 8'h00);
    repeat (3) @(negedge clk);
    quiet("off at ratio 1");
  endtask

  task automatic tWide();
    int v;
    wr(1, 2'd2, 8'h01);
    measure(1, 64, "R2");
    setCode(1, 8'h20, 64);
    measure(1, 64, "R3");
    setCode(1, 8'h23, 64);
    measure(1, 192, "R3");
    rdReg(1, 2'd1, v); check("R11", "wide code readback", v, 8'h23);
    setCode(1, 8'h1F, 192);
    measure(1, 31, "R4");
    setCode(1, 8'h04, 31);
    measure(1, 4, "R4");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vecs++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnable();
    tNarrowCodes();
    tSwitch();
    tRatioOne();
    tDisable();
    tWide();
    summary();
    $finish;
  end
endmodule